// File: doc/BRIEF.md
# Keyed Region Write-Protect Guard

This block sits beside the command engine of a 32 KB nonvolatile data array and decides, for every erase or program request, whether the target may be touched. It keeps a 32-bit protection mask in which each bit covers one 1 KB slice of the array. A set bit locks its slice against both programming and erasing.

The mask can be changed only while a protection mode is open. That mode opens after two consecutive writes to the mode port: the arming value first and the opening value second. A write of zero to the mode port closes the mode again. Mask writes made while the mode is closed are dropped.

Each request carries an operation code and an address. The block works out which mask bits the operation covers, compares them with the mask, and returns one registered verdict a cycle later. The covered bits are one bit for a program, a 512-byte page erase or a 1 KB sector erase. They are an aligned group of four bits for a 4 KB sector erase, and every bit for a whole-array erase.

Top module: `wp_region_guard`

## Requirements
- R1: After reset the mask is all zeros and protection mode is closed, so every valid operation inside the array is allowed.
- R2: Protection mode opens only when a mode write of 0x66 is followed, at the next mode write, by 0x99. Any other value cancels a pending arm. A mode write of 0x00 closes an open mode.
- R3: A mask write while protection mode is closed has no effect on the mask. A mask write while the mode is open replaces the whole mask.
- R4: Mask bit n covers addresses 0x0E00_0000 + n*0x400 through 0x0E00_0000 + n*0x400 + 0x3FF. A set bit denies both programming and erasing there.
- R5: Operation code 0 (program) and code 1 (512-byte page erase) check only the single bit of the region holding the address.
- R6: Operation code 2 (1 KB sector erase) checks exactly one bit.
- R7: Operation code 3 (4 KB sector erase) checks the four bits 4k to 4k+3 of the aligned group holding the address. It is denied if any of them is set.
- R8: Operation code 4 (whole-array erase) ignores the address and is denied if any mask bit is set.
- R9: For codes 0 to 3, an address outside 0x0E00_0000 to 0x0E00_7FFF is denied. Codes 5 to 7 are always denied.
- R10: rsp_valid rises exactly one cycle after each req_valid cycle, with exactly one of rsp_allow and rsp_deny high. All three are low otherwise.
- R11: A mask of 0x0000FFFF denies every address of the lower 16 KB and allows every address of the upper 16 KB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we | input | 1 | Mode port write strobe |
| mode_wdata | input | 8 | Mode port write value |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 32 | New mask value |
| req_valid | input | 1 | Request strobe from the command engine |
| req_op | input | 3 | Operation code (0 program, 1 page, 2 sector 1 KB, 3 sector 4 KB, 4 whole array) |
| req_addr | input | 32 | Target byte address |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_allow | output | 1 | Operation may proceed |
| rsp_deny | output | 1 | Operation is blocked |

## Verification
The bench builds the block with its default parameters: a base of 0x0E00_0000, 1 KB regions, 32 regions and groups of four. This puts every region boundary of the real array within reach, including the last byte of region 15 against the first byte of region 16, and the ends of the 4 KB groups. It also reaches the single addresses just below and just above the array. The bench walks every region at both ends under the half mask, and drives the key sequence with an interrupting value to show that the mode stays closed.

// File: rtl/wp_pkg.sv
package wp_pkg;

   typedef enum logic [2:0] {
      OP_PROG   = 3'd0,
      OP_PAGE   = 3'd1,
      OP_SECT_S = 3'd2,
      OP_SECT_L = 3'd3,
      OP_ALL    = 3'd4
   } wp_op_e;

   typedef enum logic [1:0] {
      KS_IDLE  = 2'd0,
      KS_ARMED = 2'd1,
      KS_OPEN  = 2'd2
   } key_state_e;

   localparam logic [7:0] KEY_ARM  = 8'h66;
   localparam logic [7:0] KEY_OPEN = 8'h99;
   localparam logic [7:0] KEY_EXIT = 8'h00;

endpackage

// File: rtl/wp_key_seq.sv
module wp_key_seq
   import wp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_we,
   input  logic [7:0] mode_wdata,
   output logic       prot_active
);

   key_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (mode_we) begin
         if (mode_wdata == KEY_OPEN && state_q == KS_ARMED)
            state_d = KS_OPEN;
         else if (mode_wdata == KEY_ARM)
            state_d = KS_ARMED;
         else
            state_d = KS_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= KS_IDLE;
      else        state_q <= state_d;
   end

   assign prot_active = (state_q == KS_OPEN);

endmodule

// File: rtl/wp_mask_bank.sv
module wp_mask_bank #(
   parameter int MASK_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prot_active,
   input  logic              mask_we,
   input  logic [MASK_W-1:0] mask_wdata,
   output logic [MASK_W-1:0] mask_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      mask_q <= '0;
      else if (mask_we && prot_active) mask_q <= mask_wdata;
   end

endmodule

// File: rtl/wp_span_check.sv
module wp_span_check
   import wp_pkg::*;
#(
   parameter int          ADDR_W        = 32,
   parameter logic [31:0] BASE_ADDR     = 32'h0E00_0000,
   parameter int          REGION_BYTES  = 1024,
   parameter int          NUM_REGIONS   = 32,
   parameter int          GROUP_REGIONS = 4
) (
   input  logic [NUM_REGIONS-1:0] mask,
   input  logic [2:0]             op,
   input  logic [ADDR_W-1:0]      addr,
   output logic                   allow
);

   localparam int REGION_LSB  = $clog2(REGION_BYTES);
   localparam int IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
   localparam int GROUP_LSB   = $clog2(GROUP_REGIONS);
   localparam longint ARRAY_BYTES = longint'(REGION_BYTES) * NUM_REGIONS;
   localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(ARRAY_BYTES);

   logic [ADDR_W-1:0]      offset;
   logic                   in_range;
   logic [IDX_W-1:0]       idx;
   logic [NUM_REGIONS-1:0] one_sel, grp_sel, touched;
   logic                   op_known, needs_addr;

   assign offset   = addr - BASE_A;
   assign in_range = (addr >= BASE_A) && (offset < LIMIT_A);
   assign idx      = IDX_W'(offset >> REGION_LSB);

   for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
      localparam logic [IDX_W-1:0] ID = IDX_W'(i);
      assign one_sel[i] = (idx == ID);
      assign grp_sel[i] = ((idx >> GROUP_LSB) == (ID >> GROUP_LSB));
   end

   always_comb begin
      touched    = '0;
      op_known   = 1'b1;
      needs_addr = 1'b1;
      case (wp_op_e'(op))
         OP_PROG, OP_PAGE, OP_SECT_S: touched = one_sel;
         OP_SECT_L:                   touched = grp_sel;
         OP_ALL: begin
            touched    = '1;
            needs_addr = 1'b0;
         end
         default:                     op_known = 1'b0;
      endcase
   end

   assign allow = op_known && (in_range || !needs_addr) && ((touched & mask) == '0);

endmodule

// File: rtl/wp_region_guard.sv
module wp_region_guard #(
   parameter int          ADDR_W        = 32,
   parameter logic [31:0] BASE_ADDR     = 32'h0E00_0000,
   parameter int          REGION_BYTES  = 1024,
   parameter int          NUM_REGIONS   = 32,
   parameter int          GROUP_REGIONS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   mode_we,
   input  logic [7:0]             mode_wdata,
   input  logic                   mask_we,
   input  logic [NUM_REGIONS-1:0] mask_wdata,
   input  logic                   req_valid,
   input  logic [2:0]             req_op,
   input  logic [ADDR_W-1:0]      req_addr,
   output logic                   rsp_valid,
   output logic                   rsp_allow,
   output logic                   rsp_deny
);

   if ((REGION_BYTES & (REGION_BYTES - 1)) != 0 || REGION_BYTES < 2) begin : g_bad_region
      $error("REGION_BYTES must be a power of two");
   end
   if ((NUM_REGIONS & (NUM_REGIONS - 1)) != 0 || NUM_REGIONS > 1024) begin : g_bad_count
      $error("NUM_REGIONS must be a power of two no larger than 1024");
   end
   if ((GROUP_REGIONS & (GROUP_REGIONS - 1)) != 0 || GROUP_REGIONS > NUM_REGIONS) begin : g_bad_group
      $error("GROUP_REGIONS must be a power of two within NUM_REGIONS");
   end

   logic                   prot_active;
   logic [NUM_REGIONS-1:0] mask_q;
   logic                   allow_c;
   logic                   valid_q, allow_q;

   wp_key_seq u_key (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_we    (mode_we),
      .mode_wdata (mode_wdata),
      .prot_active(prot_active)
   );

   wp_mask_bank #(.MASK_W(NUM_REGIONS)) u_mask (
      .clk        (clk),
      .rst_n      (rst_n),
      .prot_active(prot_active),
      .mask_we    (mask_we),
      .mask_wdata (mask_wdata),
      .mask_q     (mask_q)
   );

   wp_span_check #(
      .ADDR_W       (ADDR_W),
      .BASE_ADDR    (BASE_ADDR),
      .REGION_BYTES (REGION_BYTES),
      .NUM_REGIONS  (NUM_REGIONS),
      .GROUP_REGIONS(GROUP_REGIONS)
   ) u_span (
      .mask (mask_q),
      .op   (req_op),
      .addr (req_addr),
      .allow(allow_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         allow_q <= 1'b0;
      end else begin
         valid_q <= req_valid;
         allow_q <= req_valid && allow_c;
      end
   end

   assign rsp_valid = valid_q;
   assign rsp_allow = valid_q && allow_q;
   assign rsp_deny  = valid_q && !allow_q;

endmodule

// File: rtl/wp_region_guard_chk.sv
module wp_region_guard_chk #(
   parameter int          ADDR_W      = 32,
   parameter logic [31:0] BASE_ADDR   = 32'h0E00_0000,
   parameter int          ARRAY_BYTES = 32768,
   parameter int          MASK_W      = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_we,
   input logic [7:0]        mode_wdata,
   input logic              req_valid,
   input logic [2:0]        req_op,
   input logic [ADDR_W-1:0] req_addr,
   input logic              prot_active,
   input logic [MASK_W-1:0] mask_q,
   input logic              rsp_valid,
   input logic              rsp_allow,
   input logic              rsp_deny
);

   localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] HI = ADDR_W'(longint'(BASE_ADDR) + ARRAY_BYTES);

   p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_rsp_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   p_one_verdict_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot({rsp_allow, rsp_deny}));
   p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_allow && !rsp_deny);
   p_mask_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !prot_active |=> $stable(mask_q));
   p_exit_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_we && mode_wdata == 8'h00 |=> !prot_active);
   p_open_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prot_active) |-> $past(mode_we) && $past(mode_wdata) == 8'h99);
   p_whole_denied_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_op == 3'd4 && mask_q != '0 |=> rsp_deny);
   p_outside_denied_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_op != 3'd4 && (req_addr < LO || req_addr >= HI) |=> rsp_deny);

endmodule

bind wp_region_guard wp_region_guard_chk #(
   .ADDR_W     (ADDR_W),
   .BASE_ADDR  (BASE_ADDR),
   .ARRAY_BYTES(REGION_BYTES * NUM_REGIONS),
   .MASK_W     (NUM_REGIONS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_we    (mode_we),
   .mode_wdata (mode_wdata),
   .req_valid  (req_valid),
   .req_op     (req_op),
   .req_addr   (req_addr),
   .prot_active(prot_active),
   .mask_q     (mask_q),
   .rsp_valid  (rsp_valid),
   .rsp_allow  (rsp_allow),
   .rsp_deny   (rsp_deny)
);

// File: tb/wp_region_guard_tb.sv
`timescale 1ns/1ps
module wp_region_guard_tb;

   localparam logic [31:0] BASE = 32'h0E00_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_we = 1'b0;
   logic [7:0]  mode_wdata = '0;
   logic        mask_we = 1'b0;
   logic [31:0] mask_wdata = '0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = '0;
   logic [31:0] req_addr = '0;
   logic        rsp_valid, rsp_allow, rsp_deny;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   bit    exp_q[$];
   string tag_q[$];

   logic [31:0] m_mask = '0;
   int          m_key  = 0;

   always #2 clk = ~clk;

   wp_region_guard u_dut (
      .clk(clk), .rst_n(rst_n),
      .mode_we(mode_we), .mode_wdata(mode_wdata),
      .mask_we(mask_we), .mask_wdata(mask_wdata),
      .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_deny(rsp_deny)
   );

   function automatic bit model_allow(input logic [2:0] op, input logic [31:0] a);
      int idx;
      bit inside_arr;
      inside_arr = (a >= BASE) && (a < BASE + 32'h8000);
      idx = int'((a - BASE) / 32'h400);
      case (op)
         3'd0, 3'd1, 3'd2: return inside_arr && !m_mask[idx];
         3'd3: return inside_arr && (((m_mask >> ((idx / 4) * 4)) & 32'hF) == 0);
         3'd4: return m_mask == 0;
         default: return 1'b0;
      endcase
   endfunction

   task automatic send(input logic [2:0] op, input logic [31:0] a, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a;
      exp_q.push_back(model_allow(op, a));
      tag_q.push_back(tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic mode_wr(input logic [7:0] v);
      @(negedge clk);
      mode_we = 1'b1; mode_wdata = v;
      if (v == 8'h99 && m_key == 1) m_key = 2;
      else if (v == 8'h66)          m_key = 1;
      else                          m_key = 0;
      @(negedge clk);
      mode_we = 1'b0;
   endtask

   task automatic mask_wr(input logic [31:0] v);
      @(negedge clk);
      mask_we = 1'b1; mask_wdata = v;
      if (m_key == 2) m_mask = v;
      @(negedge clk);
      mask_we = 1'b0;
   endtask

   task automatic check_bit(input bit act, input bit exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b", tag, act, exp);
      end
   endtask

   // monitor: pops expected verdicts as responses appear
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check_bit(1'b1, 1'b0, "R10 unexpected response");
         end else begin
            bit e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check_bit(rsp_allow, e, t);
            check_bit(rsp_deny, !e, {t, " deny"});
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: got hang expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_bit(rsp_valid, 1'b0, "R10 valid low in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_bit(rsp_valid, 1'b0, "R10 valid low when idle");
      check_bit(rsp_allow | rsp_deny, 1'b0, "R10 verdicts low when idle");

      // R1: nothing protected out of reset
      for (int op = 0; op < 5; op++) send(3'(op), BASE + 32'h1234, "R1 reset allows");

      // R3: mask write while closed is dropped
      mask_wr(32'hFFFF_FFFF);
      send(3'd0, BASE, "R3 closed write ignored");
      send(3'd4, BASE, "R3 closed write ignored whole");

      // R2: interrupted key keeps mode closed
      mode_wr(8'h66); mode_wr(8'h55); mode_wr(8'h99);
      mask_wr(32'hFFFF_FFFF);
      send(3'd1, BASE + 32'h200, "R2 broken key stays closed");

      // R2 / R11 / R4: proper key, lower half protected
      mode_wr(8'h66); mode_wr(8'h99);
      mask_wr(32'h0000_FFFF);
      for (int n = 0; n < 32; n++) begin
         send(3'd0, BASE + 32'(n) * 32'h400, "R11 R4 region first byte");
         send(3'd1, BASE + 32'(n) * 32'h400 + 32'h3FF, "R11 R4 region last byte");
      end

      // R2 exit, R3 write after exit ignored
      mode_wr(8'h00);
      mask_wr(32'h0000_0000);
      send(3'd0, BASE + 32'h10, "R3 mask kept after exit");
      send(3'd0, BASE + 32'h4000, "R3 upper still open");

      // R5 / R6 / R7: single bit 5
      mode_wr(8'h66); mode_wr(8'h99);
      mask_wr(32'h0000_0020);
      send(3'd1, BASE + 32'h1600, "R5 page in second half of region 5");
      send(3'd1, BASE + 32'h1200, "R5 page in region 4");
      send(3'd0, BASE + 32'h17FF, "R5 program last byte region 5");
      send(3'd2, BASE + 32'h1400, "R6 sector1k region 5");
      send(3'd2, BASE + 32'h1800, "R6 sector1k region 6");
      send(3'd3, BASE + 32'h1C00, "R7 sector4k group 4-7");
      send(3'd3, BASE + 32'h2000, "R7 sector4k group 8-11");
      send(3'd3, BASE + 32'h0FFF, "R7 sector4k group 0-3");

      // R8: whole-array erase
      send(3'd4, 32'h0000_0000, "R8 whole denied with bit set");
      mask_wr(32'h8000_0000);
      send(3'd4, BASE, "R8 whole denied top bit");
      send(3'd3, BASE + 32'h7000, "R7 sector4k top group");
      mask_wr(32'h0000_0000);
      send(3'd4, 32'hFFFF_FFFF, "R8 whole allowed empty mask");

      // R9: outside range and unknown codes
      send(3'd0, BASE + 32'h8000, "R9 just above array");
      send(3'd1, BASE - 32'h1, "R9 just below array");
      send(3'd0, BASE + 32'h7FFF, "R9 last byte inside");
      for (int op = 5; op < 8; op++) send(3'(op), BASE, "R9 unknown code");

      repeat (3) @(negedge clk);
      check_bit(exp_q.size() == 0, 1'b1, "R10 all responses seen");
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule